// File: doc/BRIEF.md
# Dual Cascaded Interrupt Controller

This block combines two eight-line interrupt controllers, a primary for lines 0 to 7 and a secondary for lines 8 to 15, into one sixteen-line request space. Software reaches both through one byte-wide port interface. Each controller has a command port and a data port. Through these ports software programs the line masks and the vector base, runs the initialisation word sequence, releases interrupts with end-of-interrupt commands, and chooses whether a command-port read returns the request register or the in-service register.

Requests are latched from single-cycle set pulses. A shared tracker records the one line currently being serviced. While that tracker is empty and the CPU interrupt-enable input is high, the block picks the lowest-numbered pending, unmasked line. Line 2 is never picked, because it is the cascade input. The block marks that line in service and presents its vector together with a one-cycle strobe. No other request is issued until an end-of-interrupt releases the line. Each release is reported on a one-cycle output that carries the released line number.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, the primary mask reads 0xFC and the secondary mask reads 0xEF, so only lines 0, 1 and 12 are unmasked. Request and in-service registers are zero. Primary vectors are 0x08+i and secondary vectors are 0x70+i.
- R2: Writing 0x0A to a command port makes that controller's command-port reads return its request bits. Writing 0x0B makes them return its in-service bits. Reads return the request bits after reset.
- R3: Writing 0x10 to a command port starts an initialisation that takes two data words. Writing 0x11 starts one that takes three. The first word sets the vector base, so the vector of local line i becomes (word & 0xF8) + i. The remaining words are ignored, and data writes then return to loading the mask.
- R4: Outside initialisation, a data-port write loads the mask and a data-port read returns it. Bit i masks local line i, and a masked line is never issued.
- R5: Lines are scanned from 0 up to 15 and line 2 is skipped. The first line that is both pending and unmasked becomes the only in-service line. Its request bit clears, and int_strobe is high for exactly one cycle with int_vector holding that line's vector.
- R6: No interrupt is issued while a line is in service or while cpu_ie is low.
- R7: Command values 0x20 to 0x27 are a non-specific end-of-interrupt. On the primary they release the active line only if it is 0 to 7. On the secondary they release it only if it is 8 to 15. A release clears the line's in-service bit and pulses eoi_valid for one cycle with eoi_line set to the released line.
- R8: Command values 0x60 to 0x67 are a specific end-of-interrupt. They release the active line only if it equals the low three bits of the value, with 8 added on the secondary.
- R9: Command values 0xC0 to 0xC7, and any other command value not listed here, change nothing.
- R10: Writing 0x10 to the secondary command port sets the secondary mask to 0xFF and clears the secondary request and in-service bits. If the active line belongs to the secondary, the active-line tracker is freed, and no end-of-interrupt pulse is produced.
- R11: If a set pulse arrives for a line in the same cycle that line is issued, the request bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_set | input | 16 | One-cycle request set pulses, bit i for line i |
| cpu_ie | input | 1 | CPU interrupt enable |
| bus_wr | input | 1 | Write strobe for the port interface |
| bus_addr | input | 2 | Bit 1 selects secondary, bit 0 selects data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| int_strobe | output | 1 | One-cycle interrupt issue strobe |
| int_vector | output | 8 | Vector of the issued line |
| eoi_valid | output | 1 | One-cycle pulse when a line is released |
| eoi_line | output | 4 | Number of the released line |

## Verification
Two functions can act on the same line in the same cycle. A fresh set pulse can arrive for a line in the very cycle the arbiter issues that line and clears its request. The bench holds a set pulse for two cycles, so the second cycle coincides with the grant. It then judges the outcome at the ports: the command-port read must still show the request, and after the end-of-interrupt the same vector must be issued again. A second collision is also exercised. A secondary initialisation write lands while a secondary line is in service, and the bench confirms the tracker is freed by seeing a primary line issue straight away.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int unsigned CTRL_LINES = 8;
  localparam int unsigned ALL_LINES  = 2 * CTRL_LINES;
  localparam int unsigned LINE_W     = $clog2(ALL_LINES);
  localparam int unsigned BASE_W     = 8 - $clog2(CTRL_LINES);

  typedef logic [LINE_W-1:0] line_idx_t;

  localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
  localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
  localparam logic [7:0] CMD_INIT2   = 8'h10;
  localparam logic [7:0] CMD_INIT3   = 8'h11;
  localparam logic [4:0] GRP_EOI_NS  = 5'b00100;
  localparam logic [4:0] GRP_EOI_SP  = 5'b01100;
  localparam logic [4:0] GRP_LOWPRI  = 5'b11000;
endpackage

// File: rtl/dic_port.sv
module dic_port
  import dic_pkg::*;
#(
  parameter bit                IS_SEC   = 1'b0,
  parameter logic [7:0]        RST_MASK = 8'hFF,
  parameter logic [BASE_W-1:0] RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic [7:0]        wdata,
  input  logic              act_valid,
  input  line_idx_t         act_line,
  output logic [7:0]        mask,
  output logic [BASE_W-1:0] vbase,
  output logic              sel_isr,
  output logic              eoi_hit,
  output logic              init_clr
);
  logic [1:0]        icw_st, icw_st_nx;
  logic [1:0]        icw_last, icw_last_nx;
  logic [7:0]        mask_nx;
  logic [BASE_W-1:0] vbase_nx;
  logic              sel_isr_nx;
  logic              upd_en;
  logic              own_line, is_ns, is_sp;

  always_comb begin
    icw_st_nx   = icw_st;
    icw_last_nx = icw_last;
    mask_nx     = mask;
    vbase_nx    = vbase;
    sel_isr_nx  = sel_isr;
    if (wr_cmd) begin
      case (wdata)
        CMD_SEL_REQ: sel_isr_nx = 1'b0;
        CMD_SEL_ISR: sel_isr_nx = 1'b1;
        CMD_INIT2: begin
          icw_st_nx   = 2'd1;
          icw_last_nx = 2'd2;
          if (IS_SEC) mask_nx = 8'hFF;
        end
        CMD_INIT3: begin
          icw_st_nx   = 2'd1;
          icw_last_nx = 2'd3;
        end
        default: ;
      endcase
    end else if (wr_data) begin
      if (icw_st == 2'd0) begin
        mask_nx = wdata;
      end else begin
        if (icw_st == 2'd1) vbase_nx = wdata[7:8-BASE_W];
        icw_st_nx = (icw_st >= icw_last) ? 2'd0 : icw_st + 2'd1;
      end
    end
  end

  assign own_line = (act_line[LINE_W-1] == IS_SEC);
  assign is_ns    = (wdata[7:3] == GRP_EOI_NS);
  assign is_sp    = (wdata[7:3] == GRP_EOI_SP) && (wdata[2:0] == act_line[2:0]);
  assign eoi_hit  = wr_cmd && act_valid && own_line && (is_ns || is_sp);
  assign init_clr = IS_SEC && wr_cmd && (wdata == CMD_INIT2);
  assign upd_en   = wr_cmd || wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icw_st   <= 2'd0;
      icw_last <= 2'd2;
      mask     <= RST_MASK;
      vbase    <= RST_BASE;
      sel_isr  <= 1'b0;
    end else if (upd_en) begin
      icw_st   <= icw_st_nx;
      icw_last <= icw_last_nx;
      mask     <= mask_nx;
      vbase    <= vbase_nx;
      sel_isr  <= sel_isr_nx;
    end
  end

  p_lowpri_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && (wdata[7:3] == GRP_LOWPRI) |=> $stable(mask) && $stable(vbase) && $stable(sel_isr));

  generate
    if (IS_SEC) begin : g_sec_chk
      p_init_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd && (wdata == CMD_INIT2) |=> mask == 8'hFF);
    end
  endgenerate
endmodule

// File: rtl/dic_arbiter.sv
module dic_arbiter
  import dic_pkg::*;
#(
  parameter int unsigned SKIP_LINE = 2
) (
  input  logic [ALL_LINES-1:0] elig,
  output logic                 any,
  output line_idx_t            pick
);
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = ALL_LINES - 1; i >= 0; i--) begin
      if (elig[i] && (i != SKIP_LINE)) begin
        any  = 1'b1;
        pick = line_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
#(
  parameter int unsigned CASCADE_LINE = 2,
  parameter logic [7:0]  PRI_RST_MASK = 8'hFC,
  parameter logic [7:0]  SEC_RST_MASK = 8'hEF,
  parameter logic [7:0]  PRI_RST_VEC  = 8'h08,
  parameter logic [7:0]  SEC_RST_VEC  = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_set,
  input  logic        cpu_ie,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        int_strobe,
  output logic [7:0]  int_vector,
  output logic        eoi_valid,
  output logic [3:0]  eoi_line
);
  localparam logic [ALL_LINES-1:0] CASC_BIT = ALL_LINES'(1) << CASCADE_LINE;
  localparam logic [ALL_LINES-1:0] SEC_HALF = {{CTRL_LINES{1'b1}}, {CTRL_LINES{1'b0}}};

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [7:0]        mask_a    [2];
  logic [BASE_W-1:0] vbase_a   [2];
  logic              sel_isr_a [2];
  logic [1:0]        eoi_hit_a;
  logic [1:0]        init_clr_a;

  logic [ALL_LINES-1:0] req_q, req_nx, isr_q, isr_nx;
  logic                 act_valid_q, act_valid_nx;
  line_idx_t            act_line_q, act_line_nx;
  logic                 strobe_nx, eoi_v_nx;
  logic [7:0]           vec_nx;
  line_idx_t            eoi_l_nx;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_ctrl
      dic_port #(
        .IS_SEC  (k == 1),
        .RST_MASK((k == 0) ? PRI_RST_MASK : SEC_RST_MASK),
        .RST_BASE((k == 0) ? PRI_RST_VEC[7:8-BASE_W] : SEC_RST_VEC[7:8-BASE_W])
      ) u_port (
        .clk      (clk),
        .rst_n    (rst_q),
        .wr_cmd   (bus_wr && (bus_addr == {1'(k), 1'b0})),
        .wr_data  (bus_wr && (bus_addr == {1'(k), 1'b1})),
        .wdata    (bus_wdata),
        .act_valid(act_valid_q),
        .act_line (act_line_q),
        .mask     (mask_a[k]),
        .vbase    (vbase_a[k]),
        .sel_isr  (sel_isr_a[k]),
        .eoi_hit  (eoi_hit_a[k]),
        .init_clr (init_clr_a[k])
      );
    end
  endgenerate

  logic [ALL_LINES-1:0] elig, grant_vec, eoi_vec, clr_vec;
  logic                 any_pend, grant, eoi_any, sec_clr, release_act;
  line_idx_t            pick;

  assign elig = req_q & ~{mask_a[1], mask_a[0]} & ~CASC_BIT;

  dic_arbiter #(.SKIP_LINE(CASCADE_LINE)) u_arb (
    .elig(elig),
    .any (any_pend),
    .pick(pick)
  );

  assign grant       = cpu_ie && !act_valid_q && any_pend;
  assign grant_vec   = grant ? (ALL_LINES'(1) << pick) : '0;
  assign eoi_any     = |eoi_hit_a;
  assign eoi_vec     = eoi_any ? (ALL_LINES'(1) << act_line_q) : '0;
  assign sec_clr     = |init_clr_a;
  assign clr_vec     = sec_clr ? SEC_HALF : '0;
  assign release_act = eoi_any || (sec_clr && act_line_q[LINE_W-1]);

  always_comb begin
    req_nx       = ((req_q & ~grant_vec) | irq_set) & ~clr_vec;
    isr_nx       = (isr_q | grant_vec) & ~eoi_vec & ~clr_vec;
    act_valid_nx = act_valid_q;
    act_line_nx  = act_line_q;
    if (grant) begin
      act_valid_nx = 1'b1;
      act_line_nx  = pick;
    end else if (release_act) begin
      act_valid_nx = 1'b0;
    end
    strobe_nx = grant;
    vec_nx    = grant ? {vbase_a[pick[LINE_W-1]], pick[2:0]} : int_vector;
    eoi_v_nx  = eoi_any;
    eoi_l_nx  = eoi_any ? act_line_q : eoi_line;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      req_q       <= '0;
      isr_q       <= '0;
      act_valid_q <= 1'b0;
      act_line_q  <= '0;
      int_strobe  <= 1'b0;
      int_vector  <= '0;
      eoi_valid   <= 1'b0;
      eoi_line    <= '0;
    end else begin
      req_q       <= req_nx;
      isr_q       <= isr_nx;
      act_valid_q <= act_valid_nx;
      act_line_q  <= act_line_nx;
      int_strobe  <= strobe_nx;
      int_vector  <= vec_nx;
      eoi_valid   <= eoi_v_nx;
      eoi_line    <= eoi_l_nx;
    end
  end

  always_comb begin
    if (bus_addr[0]) bus_rdata = mask_a[bus_addr[1]];
    else if (bus_addr[1])
      bus_rdata = sel_isr_a[1] ? isr_q[15:8] : req_q[15:8];
    else
      bus_rdata = sel_isr_a[0] ? isr_q[7:0] : req_q[7:0];
  end

  p_issue_gated_r6: assert property (@(posedge clk) disable iff (!rst_q)
    int_strobe |-> $past(cpu_ie) && !$past(act_valid_q));
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_q)
    int_strobe |=> !int_strobe);
  p_isr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(isr_q));
  p_isr_matches_r5: assert property (@(posedge clk) disable iff (!rst_q)
    act_valid_q |-> isr_q == (ALL_LINES'(1) << act_line_q));
  p_isr_idle_r7: assert property (@(posedge clk) disable iff (!rst_q)
    !act_valid_q |-> isr_q == '0);
  p_cascade_never_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !isr_q[CASCADE_LINE]);
  p_eoi_frees_r7: assert property (@(posedge clk) disable iff (!rst_q)
    eoi_valid |-> $past(act_valid_q) && !act_valid_q);
  p_eoi_line_r8: assert property (@(posedge clk) disable iff (!rst_q)
    eoi_valid |-> eoi_line == $past(act_line_q));
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IRQ = 2'd2, K_NOIRQ = 2'd3;
  localparam int N_VEC = 61;

  // {req[3:0], kind[1:0], addr[1:0], data[15:0], expected[7:0]}
  localparam logic [31:0] TBL [N_VEC] = '{
    {4'd1,  K_RD,    2'd1, 16'h0000, 8'hFC},  // R1 primary mask
    {4'd1,  K_RD,    2'd3, 16'h0000, 8'hEF},  // R1 secondary mask
    {4'd1,  K_RD,    2'd0, 16'h0000, 8'h00},
    {4'd1,  K_RD,    2'd2, 16'h0000, 8'h00},
    {4'd5,  K_IRQ,   2'd0, 16'h0003, 8'h08},  // R5 line 0 beats line 1
    {4'd6,  K_RD,    2'd0, 16'h0000, 8'h02},  // R6 line 1 held back
    {4'd2,  K_WR,    2'd0, 16'h000B, 8'h00},  // R2 select in-service
    {4'd2,  K_RD,    2'd0, 16'h0000, 8'h01},
    {4'd7,  K_WR,    2'd2, 16'h0020, 8'h00},  // R7 wrong controller
    {4'd7,  K_RD,    2'd0, 16'h0000, 8'h01},
    {4'd8,  K_WR,    2'd0, 16'h0061, 8'h00},  // R8 mismatched specific
    {4'd8,  K_RD,    2'd0, 16'h0000, 8'h01},
    {4'd9,  K_WR,    2'd0, 16'h00C3, 8'h00},  // R9 lowest-priority command
    {4'd9,  K_WR,    2'd0, 16'h0055, 8'h00},  // R9 unknown command
    {4'd9,  K_RD,    2'd0, 16'h0000, 8'h01},
    {4'd9,  K_RD,    2'd1, 16'h0000, 8'hFC},
    {4'd7,  K_WR,    2'd0, 16'h0020, 8'h00},  // R7 release line 0
    {4'd5,  K_IRQ,   2'd0, 16'h0000, 8'h09},
    {4'd2,  K_RD,    2'd0, 16'h0000, 8'h02},
    {4'd8,  K_WR,    2'd0, 16'h0061, 8'h00},  // R8 matching specific
    {4'd8,  K_RD,    2'd0, 16'h0000, 8'h00},
    {4'd2,  K_WR,    2'd0, 16'h000A, 8'h00},
    {4'd4,  K_WR,    2'd1, 16'h0001, 8'h00},  // R4 mask line 0
    {4'd4,  K_RD,    2'd1, 16'h0000, 8'h01},
    {4'd4,  K_IRQ,   2'd0, 16'h0009, 8'h0B},
    {4'd6,  K_RD,    2'd0, 16'h0000, 8'h01},
    {4'd7,  K_WR,    2'd0, 16'h0020, 8'h00},
    {4'd4,  K_NOIRQ, 2'd0, 16'h0000, 8'h00},
    {4'd4,  K_WR,    2'd1, 16'h0000, 8'h00},
    {4'd4,  K_IRQ,   2'd0, 16'h0000, 8'h08},
    {4'd8,  K_WR,    2'd0, 16'h0060, 8'h00},
    {4'd4,  K_WR,    2'd3, 16'h0000, 8'h00},
    {4'd5,  K_IRQ,   2'd0, 16'h0104, 8'h70},  // R5 line 2 skipped
    {4'd8,  K_WR,    2'd2, 16'h0060, 8'h00},
    {4'd5,  K_RD,    2'd0, 16'h0000, 8'h04},
    {4'd3,  K_WR,    2'd0, 16'h0011, 8'h00},  // R3 three-word init
    {4'd3,  K_WR,    2'd1, 16'h0020, 8'h00},
    {4'd3,  K_WR,    2'd1, 16'h0004, 8'h00},
    {4'd3,  K_WR,    2'd1, 16'h0001, 8'h00},
    {4'd3,  K_WR,    2'd1, 16'h0000, 8'h00},
    {4'd3,  K_RD,    2'd1, 16'h0000, 8'h00},
    {4'd3,  K_IRQ,   2'd0, 16'h0010, 8'h24},
    {4'd7,  K_WR,    2'd0, 16'h0020, 8'h00},
    {4'd10, K_WR,    2'd2, 16'h0010, 8'h00},  // R10 secondary init
    {4'd10, K_RD,    2'd3, 16'h0000, 8'hFF},
    {4'd3,  K_WR,    2'd3, 16'h0037, 8'h00},
    {4'd3,  K_WR,    2'd3, 16'h0055, 8'h00},
    {4'd3,  K_WR,    2'd3, 16'h0000, 8'h00},
    {4'd3,  K_RD,    2'd3, 16'h0000, 8'h00},
    {4'd3,  K_IRQ,   2'd0, 16'h0200, 8'h31},  // R3 low base bits dropped
    {4'd8,  K_WR,    2'd2, 16'h0061, 8'h00},
    {4'd4,  K_WR,    2'd3, 16'h0004, 8'h00},
    {4'd4,  K_NOIRQ, 2'd0, 16'h0400, 8'h00},
    {4'd10, K_RD,    2'd2, 16'h0000, 8'h04},
    {4'd10, K_WR,    2'd2, 16'h0010, 8'h00},
    {4'd10, K_RD,    2'd2, 16'h0000, 8'h00},
    {4'd10, K_RD,    2'd3, 16'h0000, 8'hFF},
    {4'd3,  K_WR,    2'd3, 16'h0070, 8'h00},
    {4'd3,  K_WR,    2'd3, 16'h00AA, 8'h00},
    {4'd3,  K_RD,    2'd3, 16'h0000, 8'hFF},
    {4'd4,  K_WR,    2'd3, 16'h0000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_set = '0;
  logic        cpu_ie = 1'b1;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        int_strobe;
  logic [7:0]  int_vector;
  logic        eoi_valid;
  logic [3:0]  eoi_line;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  logic       last_eoi_v;
  logic [3:0] last_eoi_l;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_irq_ctrl u_dual_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .cpu_ie(cpu_ie),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_strobe(int_strobe), .int_vector(int_vector),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line)
  );

  task automatic check(input logic ok, input int rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL R%0d: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    last_eoi_v = eoi_valid; last_eoi_l = eoi_line;
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, input logic [7:0] e, input int rq);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata == e, rq, bus_rdata, e);
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk); irq_set = m;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic watch(input logic [7:0] ev, input logic want, input int rq);
    logic       seen = 1'b0;
    logic [7:0] got = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (int_strobe && !seen) begin seen = 1'b1; got = int_vector; end
    end
    if (want) check(seen && got == ev, rq, {seen, got}, {1'b1, ev});
    else      check(!seen, rq, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      logic [31:0] t;
      t = TBL[i];
      case (t[27:26])
        K_WR:    do_write(t[25:24], t[15:8]);
        K_RD:    do_read(t[25:24], t[7:0], int'(t[31:28]));
        K_IRQ: begin
          if (t[23:8] != 16'h0) pulse(t[23:8]);
          watch(t[7:0], 1'b1, int'(t[31:28]));
        end
        default: begin
          if (t[23:8] != 16'h0) pulse(t[23:8]);
          watch(8'h00, 1'b0, int'(t[31:28]));
        end
      endcase
    end

    // R6: interrupt enable low holds back a pending line
    @(negedge clk); cpu_ie = 1'b0;
    pulse(16'h0002);
    watch(8'h00, 1'b0, 6);
    cpu_ie = 1'b1;
    watch(8'h21, 1'b1, 6);
    // R7: non-specific release reports the line
    do_write(2'd0, 8'h20);
    check(last_eoi_v && last_eoi_l == 4'd1, 7, {last_eoi_v, last_eoi_l}, 5'h11);

    // R11: set pulse coinciding with the grant of the same line
    @(negedge clk); irq_set = 16'h0002;
    @(negedge clk);
    @(negedge clk); irq_set = '0;
    check(int_strobe && int_vector == 8'h21, 11, {int_strobe, int_vector}, 9'h121);
    do_read(2'd0, 8'h06, 11);
    do_write(2'd0, 8'h20);
    watch(8'h21, 1'b1, 11);
    do_write(2'd0, 8'h61);
    check(last_eoi_v && last_eoi_l == 4'd1, 8, {last_eoi_v, last_eoi_l}, 5'h11);

    // R10: secondary init while a secondary line is in service
    pulse(16'h1000);
    watch(8'h74, 1'b1, 10);
    do_write(2'd2, 8'h0B);
    do_read(2'd2, 8'h10, 10);
    do_write(2'd2, 8'h10);
    check(!last_eoi_v, 10, last_eoi_v, 0);
    do_read(2'd2, 8'h00, 10);
    do_write(2'd3, 8'h70);
    do_write(2'd3, 8'h00);
    do_write(2'd3, 8'h00);
    pulse(16'h0002);
    watch(8'h21, 1'b1, 10);
    do_write(2'd0, 8'h20);

    // R1: reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(2'd0, 8'h00, 1);
    do_read(2'd1, 8'hFC, 1);
    pulse(16'h0001);
    watch(8'h08, 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule